// File: doc/BRIEF.md
# Four-Channel Programmable Clock Divider

The block takes a single fast parent clock and produces four divided rates for the bus, graphics, video and display domains. Each channel produces two outputs in the parent domain. One is a one-cycle enable pulse at the end of every divided period. The other is a phase level that is high in the first part of the period and low in the rest.

Software reaches the block through two 32-bit control words that can be read and written. The first word holds a 6-bit divide field and a load strobe for each channel. The second word holds the run bit, which releases the dividers. A channel copies its field only when its load strobe rises. The graphics, video and display fields hold the ratio directly. The bus field holds a code that is translated through a fixed lookup.

A channel switches to a newly loaded ratio only at the end of the period in progress. This means a ratio change never produces a shortened period.

Top module: `cdiv_quad`

## Requirements
- R1: After reset, both control words read 0, every tick and phase output is low, and every channel's ratio is 1.
- R2: Control word A is at byte offset 0 and control word B at byte offset 4. A read returns the raw stored value of the word. Any other offset reads 0, and writes to other offsets are dropped.
- R3: Bit 10 of word B is the run bit, and 0 means held. While it is 0, every counter stays at its start, all tick and phase outputs are low, and load strobes are ignored.
- R4: In word A, channel c (0 = bus, 1 = graphics, 2 = video, 3 = display) has its 6-bit field at bits 1+7c up to 6+7c and its load strobe at bit 7+7c.
- R5: Bus field codes 1 to 10 select ratios 2, 1, 3, 4, 6, 5, 7, 8, 10 and 9, in that order.
- R6: For channels 1 to 3, the field value is the ratio itself, from 1 to 63.
- R7: A load of an invalid code leaves the channel's ratio unchanged. Bus code 0 and bus codes 11 to 63 are invalid, and field 0 is invalid on channels 1 to 3.
- R8: A channel takes a new ratio only on a 0-to-1 change of its load strobe. Changing the field while the strobe stays 0 has no effect. Changing the field while the strobe stays 1 also has no effect.
- R9: A loaded ratio first takes effect after the next tick of that channel. The period in progress keeps its old length.
- R10: For ratio r, tick is high for one cycle in every r cycles, in the last cycle of the period. Phase is high for the first floor(r/2) cycles of the period and low for the rest. For r = 1, tick and phase are both high on every cycle.
- R11: Loading one channel does not change the ratio or timing of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| tick | output | NCH | Per-channel end-of-period enable |
| phase | output | NCH | Per-channel divided clock level |

## Verification
The bench walks every bus code, including codes 0, 11 and 63, which must leave the ratio unchanged. A design with a shifted or identity lookup would show the wrong period, and one that accepts an invalid code would give a zero or oversized period. A ratio is loaded partway through a 40-cycle period, and the bench checks that this period still lasts exactly 40 cycles. A design that swaps the ratio immediately would produce a short runt period. The bench also changes the field while the strobe stays high, and loads a ratio while the run bit is clear. A level-sensitive or ungated load would wrongly change the period in both cases. Ratio 1 and odd ratios are measured for phase width, which exposes off-by-one errors in the high phase.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int CD_FIELD_W = 6;
    localparam int CD_SLOT_W  = CD_FIELD_W + 1;

    typedef logic [CD_FIELD_W-1:0] ratio_t;

    typedef enum logic {
        MAP_TABLE  = 1'b0,
        MAP_DIRECT = 1'b1
    } map_kind_e;

    typedef struct packed {
        logic   ok;
        ratio_t ratio;
    } decoded_t;

    function automatic int unsigned field_lsb(int unsigned ch);
        return 1 + ch * CD_SLOT_W;
    endfunction

    function automatic int unsigned strobe_pos(int unsigned ch);
        return field_lsb(ch) + CD_FIELD_W;
    endfunction

    function automatic decoded_t decode_code(map_kind_e kind, ratio_t code);
        decoded_t d;
        d.ok    = 1'b1;
        d.ratio = code;
        if (kind == MAP_TABLE) begin
            case (code)
                ratio_t'(1):  d.ratio = ratio_t'(2);
                ratio_t'(2):  d.ratio = ratio_t'(1);
                ratio_t'(3):  d.ratio = ratio_t'(3);
                ratio_t'(4):  d.ratio = ratio_t'(4);
                ratio_t'(5):  d.ratio = ratio_t'(6);
                ratio_t'(6):  d.ratio = ratio_t'(5);
                ratio_t'(7):  d.ratio = ratio_t'(7);
                ratio_t'(8):  d.ratio = ratio_t'(8);
                ratio_t'(9):  d.ratio = ratio_t'(10);
                ratio_t'(10): d.ratio = ratio_t'(9);
                default: begin
                    d.ok    = 1'b0;
                    d.ratio = ratio_t'(1);
                end
            endcase
        end else begin
            d.ok = (code != '0);
        end
        return d;
    endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NCH        = 4,
    parameter int RUN_BIT    = 10,
    parameter int CTRL_A_OFF = 0,
    parameter int CTRL_B_OFF = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      run,
    output logic [NCH-1:0][CD_FIELD_W-1:0] code,
    output logic [NCH-1:0]            strobe
);

    localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(CTRL_A_OFF);
    localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(CTRL_B_OFF);

    logic [DATA_W-1:0] ctrl_a;
    logic [DATA_W-1:0] ctrl_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_ADDR) ctrl_a <= wr_data;
            if (wr_addr == B_ADDR) ctrl_b <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr == A_ADDR)      rd_data = ctrl_a;
        else if (rd_addr == B_ADDR) rd_data = ctrl_b;
        else                        rd_data = '0;
    end

    assign run = ctrl_b[RUN_BIT];

    for (genvar c = 0; c < NCH; c++) begin : g_slice
        localparam int LSB = field_lsb(c);
        localparam int STB = strobe_pos(c);
        assign code[c]   = ctrl_a[LSB +: CD_FIELD_W];
        assign strobe[c] = ctrl_a[STB];
    end

endmodule

// File: rtl/cdiv_loader.sv
module cdiv_loader
    import cdiv_pkg::*;
#(
    parameter map_kind_e KIND = MAP_DIRECT
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   strobe,
    input  ratio_t code,
    output ratio_t pending
);

    logic     strobe_q;
    logic     rise;
    decoded_t dec;

    assign rise = strobe & ~strobe_q;
    assign dec  = decode_code(KIND, code);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            pending  <= ratio_t'(1);
        end else begin
            strobe_q <= strobe;
            if (run && rise && dec.ok) pending <= dec.ratio;
        end
    end

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
    import cdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  ratio_t pending,
    output ratio_t cur,
    output logic   tick,
    output logic   phase
);

    ratio_t cnt;
    logic   wrap;
    ratio_t hi_len;

    assign wrap   = (cnt == cur - 1'b1);
    assign hi_len = cur >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cur <= ratio_t'(1);
        end else if (!run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
            cur <= pending;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick  = run & wrap;
    assign phase = run & ((cur == ratio_t'(1)) | (cnt < hi_len));

endmodule

// File: rtl/cdiv_quad.sv
module cdiv_quad
    import cdiv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NCH      = 4,
    parameter int RUN_BIT  = 10,
    parameter int TABLE_CH = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    tick,
    output logic [NCH-1:0]    phase
);

    logic                          run;
    logic [NCH-1:0][CD_FIELD_W-1:0] code;
    logic [NCH-1:0]                strobe;
    logic [NCH-1:0][CD_FIELD_W-1:0] pending;
    logic [NCH-1:0][CD_FIELD_W-1:0] cur_ratio;

    cdiv_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NCH    (NCH),
        .RUN_BIT(RUN_BIT)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .run    (run),
        .code   (code),
        .strobe (strobe)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam map_kind_e KIND = (c == TABLE_CH) ? MAP_TABLE : MAP_DIRECT;

        cdiv_loader #(.KIND(KIND)) u_load (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .strobe (strobe[c]),
            .code   (code[c]),
            .pending(pending[c])
        );

        cdiv_counter u_cnt (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .pending(pending[c]),
            .cur    (cur_ratio[c]),
            .tick   (tick[c]),
            .phase  (phase[c])
        );
    end

endmodule

// File: rtl/cdiv_quad_chk.sv
module cdiv_quad_chk
    import cdiv_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int TABLE_CH = 0
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          run,
    input logic [NCH-1:0]                tick,
    input logic [NCH-1:0]                phase,
    input logic [NCH-1:0][CD_FIELD_W-1:0] cur
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tick == '0 && phase == '0));

    a_r5_table_range: assert property (@(posedge clk) disable iff (rst)
        (cur[TABLE_CH] >= CD_FIELD_W'(1) && cur[TABLE_CH] <= CD_FIELD_W'(10)));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r3_hold_low: assert property (@(posedge clk) disable iff (rst)
            !run |-> (!tick[c] && !phase[c]));

        a_r7_ratio_nonzero: assert property (@(posedge clk) disable iff (rst)
            cur[c] != '0);

        a_r9_swap_at_wrap: assert property (@(posedge clk) disable iff (rst)
            !$stable(cur[c]) |-> $past(tick[c]));

        a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
            tick[c] |=> (!tick[c] || cur[c] == CD_FIELD_W'(1)));
    end

endmodule

bind cdiv_quad cdiv_quad_chk #(.NCH(NCH), .TABLE_CH(TABLE_CH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick),
    .phase(phase),
    .cur  (cur_ratio)
);

// File: tb/tb_cdiv_quad.sv
module tb_cdiv_quad;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NC = 4;
    localparam int NV = 21;

    // entry = {channel[1:0], code[5:0], expected ratio[5:0]}; 0 means "unchanged"
    localparam logic [13:0] VEC [0:NV-1] = '{
        {2'd0, 6'd1,  6'd2},  {2'd0, 6'd2,  6'd1},  {2'd0, 6'd3,  6'd3},
        {2'd0, 6'd4,  6'd4},  {2'd0, 6'd5,  6'd6},  {2'd0, 6'd6,  6'd5},
        {2'd0, 6'd7,  6'd7},  {2'd0, 6'd8,  6'd8},  {2'd0, 6'd9,  6'd10},
        {2'd0, 6'd10, 6'd9},  {2'd0, 6'd0,  6'd0},  {2'd0, 6'd11, 6'd0},
        {2'd0, 6'd63, 6'd0},  {2'd1, 6'd63, 6'd63}, {2'd1, 6'd0,  6'd0},
        {2'd1, 6'd2,  6'd2},  {2'd2, 6'd7,  6'd7},  {2'd2, 6'd1,  6'd1},
        {2'd3, 6'd4,  6'd4},  {2'd3, 6'd0,  6'd0},  {2'd3, 6'd33, 6'd33}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NC-1:0] tick;
    logic [NC-1:0] phase;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [DW-1:0] a_shadow = '0;
    int model [0:NC-1];

    cdiv_quad dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .phase(phase)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic load_ch(input int ch, input logic [5:0] code);
        logic [DW-1:0] w;
        int lsb;
        lsb = 1 + 7 * ch;
        w = a_shadow;
        w[lsb +: 6] = code;
        w[lsb + 6] = 1'b0;
        wr(4'd0, w);
        wr(4'd0, w | (32'd1 << (lsb + 6)));
        repeat (13) @(negedge clk);
        wr(4'd0, w);
        a_shadow = w;
    endtask

    // advance until the next tick; returns cycles taken and phase-high count
    task automatic wait_tick(input int ch, output int n, output int hi);
        n = 0; hi = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            n++;
            if (phase[ch]) hi++;
            if (tick[ch]) break;
        end
        if (!tick[ch]) n = 0;
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int d0, d1;
        wait_tick(ch, d0, d1);
        wait_tick(ch, d0, d1);
        wait_tick(ch, per, hi);
    endtask

    function automatic int hi_of(input int r);
        return (r == 1) ? 1 : r / 2;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        int per, hi, t0, t1, t2, bad;
        for (int c = 0; c < NC; c++) model[c] = 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(4'd0, r); check("R1 ctrl A reset", r, 0);
        rd(4'd4, r); check("R1 ctrl B reset", r, 0);
        check("R1 tick low", tick, 0);
        check("R1 phase low", phase, 0);

        // R2: raw readback while held (loads ignored, R3)
        wr(4'd0, 32'h5A5A_A55A);
        wr(4'd4, 32'hFFFF_FBFF);
        wr(4'd8, 32'h1234_5678);
        rd(4'd0, r); check("R2 ctrl A raw", r, 32'h5A5A_A55A);
        rd(4'd4, r); check("R2 ctrl B raw", r, 32'hFFFF_FBFF);
        rd(4'd8, r); check("R2 other offset", r, 0);
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0000_0400);
        rd(4'd4, r); check("R2 run word", r, 32'h0000_0400);

        // R1/R10: default ratio 1 -> tick and phase every cycle
        for (int c = 0; c < NC; c++) begin
            measure(c, per, hi);
            check("R1 R10 ratio-1 period", per, 1);
            check("R10 ratio-1 phase", hi, 1);
        end

        // Vector walk: R4 R5 R6 R7 R10 R11
        for (int k = 0; k < NV; k++) begin
            int ch, ex;
            ch = int'(VEC[k][13:12]);
            ex = int'(VEC[k][5:0]);
            load_ch(ch, VEC[k][11:6]);
            if (ex != 0) model[ch] = ex;
            measure(ch, per, hi);
            if (ex == 0)       check("R7 invalid code keeps ratio", per, model[ch]);
            else if (ch == 0)  check("R5 R4 bus lookup period", per, model[ch]);
            else               check("R6 R4 direct ratio period", per, model[ch]);
            check("R10 phase width", hi, hi_of(model[ch]));
            if (k == 15) begin
                measure(2, per, hi);
                check("R11 video untouched by graphics load", per, model[2]);
            end
        end

        // R9: load mid-period; running period keeps its length
        load_ch(1, 6'd40);
        model[1] = 40;
        measure(1, per, hi);
        check("R6 ratio 40", per, 40);
        t0 = cyc;
        repeat (5) @(negedge clk);
        load_ch(1, 6'd3);
        wait_tick(1, per, hi);
        t1 = cyc;
        check("R9 period in progress keeps old length", t1 - t0, 40);
        wait_tick(1, per, hi);
        t2 = cyc;
        check("R9 new ratio after wrap", t2 - t1, 3);
        model[1] = 3;
        measure(2, per, hi);
        check("R11 video after graphics swap", per, model[2]);

        // R8: only a rising strobe loads
        begin
            logic [DW-1:0] w;
            w = a_shadow;
            w[22 +: 6] = 6'd5; w[28] = 1'b0;
            wr(4'd0, w);
            measure(3, per, hi);
            check("R8 field change with strobe low", per, 33);
            wr(4'd0, w | (32'd1 << 28));
            measure(3, per, hi);
            check("R8 rising strobe loads", per, 5);
            w[22 +: 6] = 6'd9;
            wr(4'd0, w | (32'd1 << 28));
            measure(3, per, hi);
            check("R8 field change with strobe held high", per, 5);
            wr(4'd0, w);
            a_shadow = w;
            model[3] = 5;
        end

        // R3: hold -> outputs low, loads ignored
        wr(4'd4, 32'h0);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tick != 0 || phase != 0) bad++;
        end
        check("R3 outputs low while held", bad, 0);
        load_ch(1, 6'd10);
        rd(4'd0, r); check("R3 R2 field stored while held", r[13:8], 10);
        wr(4'd4, 32'h0000_0400);
        measure(1, per, hi);
        check("R3 load ignored while held", per, 3);
        measure(3, per, hi);
        check("R3 display resumes ratio", per, 5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule